// File: doc/BRIEF.md
# Hitless Reference Switch Phase Compensator

This block sits in front of a phase-locked loop. It runs on a fast sampling clock and receives two frame-rate reference pulse trains. A select input picks one of them. The block also receives a feedback pulse taken from the loop output. It does not pass the chosen reference straight to the loop. Instead it produces a virtual reference pulse, once per frame, placed a programmable number of sampling ticks after the selected reference. The block measures the phase of the feedback against the selected reference in ticks, and that measurement sets the offset.

When the select input changes while compensation is on, the virtual pulse keeps its old timing until the next measurement against the new reference completes. The block then keeps that measured offset, so the loop sees no phase step. Compensation is on when either a manual enable or an auto-enable from external state control is high. When compensation is off, the offset is pulled toward zero by at most one tick per reference frame, so the output drifts onto the new reference at a bounded slope. An active-low clear input, filtered against short glitches, resets the offset.

Top module: `hitlessRefComp`

## Requirements
- R1: `selB` low selects `refA` and high selects `refB`, through one register stage. With the offset at o, the virtual pulse is sampled FRAME_TICKS/2 + o + 1 clock edges after the selected reference pulse is sampled.
- R2: `virtRef` is a single-cycle pulse. While the offset is constant, it repeats exactly once every FRAME_TICKS cycles.
- R3: The measured offset is the tick count from the selected reference pulse to the next feedback pulse, minus FRAME_TICKS/2. The count saturates at FRAME_TICKS-1, so the offset always lies in [-FRAME_TICKS/2, FRAME_TICKS-1-FRAME_TICKS/2].
- R4: When the registered select changes, reference pulses stop re-timing the virtual pulse. The first measurement completed after a new reference pulse replaces the offset. With compensation on, the interval between virtual pulses stays exactly FRAME_TICKS across the switch.
- R5: Compensation is on when `manEn` or `autoEn` is high. While it is on, `appliedOfs` changes only on a switch latch or a clear.
- R6: With compensation off, each selected reference pulse outside a pending switch moves `appliedOfs` one tick toward zero. Virtual pulse intervals stay within FRAME_TICKS±1, and the virtual pulse finally aligns with the selected reference at zero offset. A switch made while compensation is off is latched first and then slewed.
- R7: `appliedOfs` becomes zero on the clock after `clrN` has been sampled low on CLR_TICKS consecutive edges. A shorter low pulse leaves it unchanged.
- R8: After reset, `appliedOfs` is zero and `virtRef` stays low until the first selected reference pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| refA | input | 1 | Reference A, one-cycle pulse per frame |
| refB | input | 1 | Reference B, one-cycle pulse per frame |
| selB | input | 1 | Reference select (0 = A, 1 = B) |
| fbPulse | input | 1 | Feedback pulse from the loop output |
| manEn | input | 1 | Manual compensation enable |
| autoEn | input | 1 | Auto-enable from external state control |
| clrN | input | 1 | Active-low offset clear, glitch filtered |
| virtRef | output | 1 | Virtual reference pulse |
| appliedOfs | output | $clog2(FRAME_TICKS)+1 | Signed offset currently applied, in ticks |

## Verification
The bench builds the block with FRAME_TICKS = 32 and CLR_TICKS = 5. At that size every phase of reference B relative to reference A can be swept: all 32 offsets, including both saturation ends of the signed range. Each offset goes through reset, alignment, switch and a full slew back to zero within a few thousand cycles. The small clear filter also lets both the just-too-short and the just-long-enough clear pulse be exercised directly. The feedback input is tied to the virtual output, which closes an ideal loop so that the expected offsets follow from the reference phases alone.

// File: rtl/hitlessPkg.sv
package hitlessPkg;
  // Strobes handed from the control path to the datapath each cycle
  typedef struct packed {
    logic refEdge;    // selected reference pulse this cycle
    logic switchNow;  // registered select just changed
    logic pendWin;    // switch pending, reference re-timing suspended
    logic slewEn;     // compensation off, offset decays toward zero
    logic clearOfs;   // filtered clear fired
  } ctrlStrobe_t;
endpackage

// File: rtl/hitlessRefCtrl.sv
module hitlessRefCtrl
  import hitlessPkg::*;
#(
  parameter int CLR_TICKS = 30,
  localparam int LW = $clog2(CLR_TICKS + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refA,
  input  logic        refB,
  input  logic        selB,
  input  logic        manEn,
  input  logic        autoEn,
  input  logic        clrN,
  input  logic        measDone,
  output ctrlStrobe_t strb
);
  localparam logic [LW-1:0] LOW_SAT  = LW'(CLR_TICKS);
  localparam logic [LW-1:0] LOW_FIRE = LW'(CLR_TICKS - 1);

  logic          selQ, selQQ, pendQ;
  logic [LW-1:0] lowCnt;
  logic          switchNow;

  assign switchNow = selQ ^ selQQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= 1'b0;
      selQQ  <= 1'b0;
      pendQ  <= 1'b0;
      lowCnt <= '0;
    end else begin
      selQ  <= selB;
      selQQ <= selQ;
      if (switchNow)     pendQ <= 1'b1;
      else if (measDone) pendQ <= 1'b0;
      if (clrN)                  lowCnt <= '0;
      else if (lowCnt != LOW_SAT) lowCnt <= lowCnt + 1'b1;
    end
  end

  always_comb begin
    strb.refEdge   = selQ ? refB : refA;
    strb.switchNow = switchNow;
    strb.pendWin   = pendQ | switchNow;
    strb.slewEn    = ~(manEn | autoEn);
    strb.clearOfs  = ~clrN & (lowCnt == LOW_FIRE);
  end
endmodule

// File: rtl/hitlessRefDatapath.sv
module hitlessRefDatapath
  import hitlessPkg::*;
#(
  parameter int FRAME_TICKS = 12500,
  localparam int CW = $clog2(FRAME_TICKS),
  localparam int OFS_W = CW + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strb,
  input  logic                    fbPulse,
  output logic                    measDone,
  output logic                    virtRef,
  output logic signed [OFS_W-1:0] appliedOfs
);
  localparam int HALF = FRAME_TICKS / 2;
  localparam logic [CW-1:0] LAST = CW'(FRAME_TICKS - 1);
  localparam logic signed [OFS_W-1:0] HALF_S = OFS_W'(HALF);
  localparam logic signed [OFS_W-1:0] ONE_S  = OFS_W'(1);

  logic [CW-1:0]           mCnt, vCnt, lagLoad;
  logic                    armed, vLive, loadVirt, slewNow;
  logic signed [OFS_W-1:0] ofsQ, measVal;

  // Measured lag, re-centred so the slew never crosses the frame wrap
  assign measVal  = $signed({1'b0, mCnt}) - HALF_S;
  assign lagLoad  = CW'(ofsQ + HALF_S);
  assign loadVirt = strb.refEdge & ~strb.pendWin;
  assign measDone = armed & fbPulse & ~strb.switchNow;
  assign slewNow  = loadVirt & strb.slewEn & (ofsQ != '0);

  // Measurement stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mCnt  <= LAST;
      armed <= 1'b0;
    end else begin
      if (strb.refEdge) begin
        mCnt  <= '0;
        armed <= 1'b1;
      end else begin
        if (mCnt != LAST) mCnt <= mCnt + 1'b1;
        if (strb.switchNow || measDone) armed <= 1'b0;
      end
    end
  end

  // Offset storage
  always_ff @(posedge clk) begin
    if (!rstN)                          ofsQ <= '0;
    else if (strb.clearOfs)             ofsQ <= '0;
    else if (measDone && strb.pendWin)  ofsQ <= measVal;
    else if (slewNow)                   ofsQ <= ofsQ[OFS_W-1] ? ofsQ + ONE_S : ofsQ - ONE_S;
  end

  // Virtual reference trigger: down-counter modulo the frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vCnt  <= LAST;
      vLive <= 1'b0;
    end else if (loadVirt) begin
      vCnt  <= lagLoad;
      vLive <= 1'b1;
    end else if (vCnt == '0) begin
      vCnt <= LAST;
    end else begin
      vCnt <= vCnt - 1'b1;
    end
  end

  assign virtRef    = vLive & (vCnt == '0);
  assign appliedOfs = ofsQ;
endmodule

// File: rtl/hitlessRefComp.sv
module hitlessRefComp
  import hitlessPkg::*;
#(
  parameter int FRAME_TICKS = 12500,
  parameter int CLR_TICKS = 30,
  localparam int OFS_W = $clog2(FRAME_TICKS) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    refA,
  input  logic                    refB,
  input  logic                    selB,
  input  logic                    fbPulse,
  input  logic                    manEn,
  input  logic                    autoEn,
  input  logic                    clrN,
  output logic                    virtRef,
  output logic signed [OFS_W-1:0] appliedOfs
);
  ctrlStrobe_t ctrlS;
  logic        measDone;

  hitlessRefCtrl #(.CLR_TICKS(CLR_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .refA(refA), .refB(refB), .selB(selB),
    .manEn(manEn), .autoEn(autoEn), .clrN(clrN), .measDone(measDone),
    .strb(ctrlS)
  );

  hitlessRefDatapath #(.FRAME_TICKS(FRAME_TICKS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(ctrlS), .fbPulse(fbPulse),
    .measDone(measDone), .virtRef(virtRef), .appliedOfs(appliedOfs)
  );
endmodule

// File: rtl/hitlessRefComp_chk.sv
module hitlessRefComp_chk
  import hitlessPkg::*;
#(
  parameter int FRAME_TICKS = 12500,
  parameter int OFS_W = 15
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    manEn,
  input logic                    autoEn,
  input logic                    virtRef,
  input logic signed [OFS_W-1:0] appliedOfs,
  input ctrlStrobe_t             ctrlS,
  input logic                    measDone
);
  localparam logic signed [OFS_W-1:0] LO = OFS_W'(-(FRAME_TICKS / 2));
  localparam logic signed [OFS_W-1:0] HI = OFS_W'(FRAME_TICKS - FRAME_TICKS / 2 - 1);
  localparam logic [OFS_W-1:0] PLUS1  = {{(OFS_W-1){1'b0}}, 1'b1};
  localparam logic [OFS_W-1:0] MINUS1 = {OFS_W{1'b1}};

  logic [OFS_W-1:0] prevOfs, ofsStep;
  logic             latchNow;

  always_ff @(posedge clk) prevOfs <= appliedOfs;
  assign ofsStep  = appliedOfs - prevOfs;
  assign latchNow = measDone & ctrlS.pendWin;

  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (appliedOfs >= LO) && (appliedOfs <= HI)); // R3

  AST_VIRT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    virtRef |=> !virtRef); // R2

  AST_HOLD_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    ((manEn || autoEn) && !ctrlS.clearOfs && !latchNow) |=> $stable(appliedOfs)); // R5

  AST_SLEW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (!(manEn || autoEn) && !ctrlS.clearOfs && !latchNow) |=>
      ((ofsStep == '0) || (ofsStep == PLUS1) || (ofsStep == MINUS1))); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctrlS.clearOfs |=> (appliedOfs == '0)); // R7
endmodule

bind hitlessRefComp hitlessRefComp_chk #(.FRAME_TICKS(FRAME_TICKS), .OFS_W(OFS_W)) chk_i (
  .clk(clk), .rstN(rstN), .manEn(manEn), .autoEn(autoEn), .virtRef(virtRef),
  .appliedOfs(appliedOfs), .ctrlS(ctrlS), .measDone(measDone)
);

// File: tb/hitlessRefComp_tb_top.sv
module hitlessRefComp_tb_top;
  localparam int F    = 32;
  localparam int HALF = F / 2;
  localparam int CT   = 5;
  localparam int OW   = $clog2(F) + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic refA = 1'b0, refB = 1'b0, selB = 1'b0;
  logic manEn = 1'b0, autoEn = 1'b0, clrN = 1'b1;
  logic virtRef, fbPulse;
  logic signed [OW-1:0] ofsOut;

  int cyc = 0, bPhase = 0, lastV = -1, lastPhase = -1, mode = 0;
  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  assign fbPulse = virtRef;  // ideal loop: feedback follows virtual reference

  hitlessRefComp #(.FRAME_TICKS(F), .CLR_TICKS(CT)) dut_i (
    .clk(clk), .rstN(rstN), .refA(refA), .refB(refB), .selB(selB),
    .fbPulse(fbPulse), .manEn(manEn), .autoEn(autoEn), .clrN(clrN),
    .virtRef(virtRef), .appliedOfs(ofsOut)
  );

  always #2 clk = ~clk;

  // Observe virtual pulses and drive the two reference trains
  always @(negedge clk) begin
    int iv;
    if (virtRef === 1'b1) begin
      if (mode != 0 && lastV >= 0) begin
        iv = cyc - lastV;
        nChk++;
        if (mode == 1 && iv != F) begin
          nBad++;
          $display("FAIL R2 R4: interval actual %0d expected %0d", iv, F);
        end
        if (mode == 2 && (iv < F - 1 || iv > F + 1)) begin
          nBad++;
          $display("FAIL R6: interval actual %0d expected %0d..%0d", iv, F - 1, F + 1);
        end
      end
      lastV = cyc;
      lastPhase = cyc % F;
    end
    cyc++;
    refA = (cyc % F == 0);
    refB = (cyc % F == bPhase);
  end

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitFrames(int n);
    repeat (n * F) @(negedge clk);
  endtask

  task automatic doReset();
    mode = 0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 offset", int'(ofsOut), 0);
    chk("R8 virtRef", int'(virtRef), 0);
    rstN = 1'b1;
    lastV = -1;
  endtask

  function automatic int expOfs(int d);
    int lag;
    lag = ((HALF - d) % F + F) % F;
    return lag - HALF;
  endfunction

  initial begin
    for (int d = 0; d < F; d++) begin
      bit disSw;
      disSw = (d % 4 == 3);
      bPhase = d; selB = 1'b0; manEn = 1'b0; autoEn = 1'b0; clrN = 1'b1;
      @(negedge clk);
      doReset();
      if (!disSw) begin
        if (d % 2 == 1) autoEn = 1'b1;  // R5 auto-enable alone
        else manEn = 1'b1;
      end
      waitFrames(3);
      lastV = -1;
      mode = disSw ? 2 : 1;
      waitFrames(3);
      chk("R1 phase on A", lastPhase, HALF);
      selB = 1'b1;
      waitFrames(4);
      if (!disSw) begin
        chk("R3 R4 latched offset", int'(ofsOut), expOfs(d));
        chk("R4 no phase jump", lastPhase, HALF);
        chk("R5 held offset", int'(ofsOut), expOfs(d));
        manEn = 1'b0; autoEn = 1'b0;
        mode = 2;
      end
      waitFrames(20);
      chk("R6 offset decayed", int'(ofsOut), 0);
      chk("R1 R6 phase on B", lastPhase, (d + HALF) % F);
    end

    // Clear filter
    bPhase = 10; selB = 1'b0; manEn = 1'b0; autoEn = 1'b0;
    @(negedge clk);
    doReset();
    manEn = 1'b1;
    waitFrames(2);
    selB = 1'b1;
    waitFrames(3);
    chk("R7 before clear", int'(ofsOut), expOfs(10));
    clrN = 1'b0;
    repeat (CT - 1) @(negedge clk);
    clrN = 1'b1;
    waitFrames(1);
    chk("R7 short clear ignored", int'(ofsOut), expOfs(10));
    clrN = 1'b0;
    repeat (CT) @(negedge clk);
    clrN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 clear applied", int'(ofsOut), 0);
    waitFrames(2);
    chk("R7 R1 phase after clear", lastPhase, (10 + HALF) % F);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule